// File: doc/BRIEF.md
# Tone Cadence Timer

This block sets the on/off rhythm of a single tone oscillator. While the master enable is high, it gates the oscillator on for an active period and off for an inactive period, and repeats that pair for as long as the enable stays high. A 16-bit down-counter times both periods. The counter moves only on a one-cycle strobe that marks each 8 kHz sample. At the start of each phase, the counter is loaded from that phase's length input.

Each timer has its own enable, so the block can also hold a tone on without end, or play a single burst. An optional zero-cross wait keeps the tone on after the active period has timed out, until the oscillator sample passes through zero, so that the cut-off does not click. Each timer expiry sets a sticky status bit, and software clears that bit with a one-cycle clear pulse. The interrupt line combines the status bits that are set with their individual masks.

Top module: `tone_cadence_timer`

## Requirements
- R1: After reset, `toneOn`, `status` and `irq` are all 0.
- R2: When `syncStart` is 0, `toneOn` goes high at the first clock edge at which `oscEnable` is high while the block is idle. When `syncStart` is 1, the block waits for the first edge at which `oscEnable` and `tick` are both high.
- R3: With both timers enabled and no zero-cross wait, the tone is on for exactly `activeLen` ticks and then off for exactly `inactiveLen` ticks. The pair repeats for as long as `oscEnable` stays high.
- R4: A length value of zero counts as one tick.
- R5: While `activeTimerEn` is 0, an active period never ends, so `toneOn` stays high.
- R6: If `inactiveTimerEn` is 0 when the active period ends, the tone goes off and stays off until `oscEnable` is dropped and raised again.
- R7: When `zeroCrossEn` is 1, the tone stays on after the active expiry until a tick whose `oscSample` is either exactly zero or has a sign bit that differs from the sample at the previous tick.
- R8: `status[0]` is set by an active-timer expiry and `status[1]` by an inactive-timer expiry. Each bit stays set until a 1 is pulsed on the matching bit of `statusClr`.
- R9: If an expiry and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when some bit of `status & intEnable` is 1. `intEnable` has no effect on `status`.
- R11: When `oscEnable` is 0 at a clock edge, `toneOn` is 0 after that edge and the sequence returns to idle. `status` is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, one per sample period |
| oscEnable | input | 1 | Master enable for the cadence sequence |
| syncStart | input | 1 | 1 = the tone starts on the next tick |
| activeTimerEn | input | 1 | Enables the active-period timer |
| inactiveTimerEn | input | 1 | Enables the inactive period (repetition) |
| zeroCrossEn | input | 1 | Delays the tone-off until a zero crossing |
| activeLen | input | 16 | Active period length, in ticks |
| inactiveLen | input | 16 | Inactive period length, in ticks |
| oscSample | input | 16 | Signed oscillator output sample |
| intEnable | input | 2 | Per-bit interrupt mask (bit 0 active, bit 1 inactive) |
| statusClr | input | 2 | Write-one-to-clear pulses for `status` |
| toneOn | output | 1 | Oscillator gate |
| status | output | 2 | Sticky expiry flags (bit 0 active, bit 1 inactive) |
| irq | output | 1 | Interrupt request |

## Verification
Every change of state happens at the clock edge that samples the cause. A tick at the final count changes `toneOn` and the matching `status` bit at that edge. A change of `oscEnable` is seen one edge later. `irq` follows `status` and `intEnable` within the same cycle, with no register in between. The bench changes inputs only on falling edges and advances its own cadence model at each rising edge. It then compares the outputs at the next falling edge, so every expected value is checked in the cycle in which it is due.

// File: rtl/tone_cadence_pkg.sv
package tone_cadence_pkg;
  localparam int NUM_EXP = 2;
  localparam int EXP_ACTIVE = 0;
  localparam int EXP_INACTIVE = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_DRAIN,
    ST_INACTIVE,
    ST_DONE
  } cadState_t;

  typedef struct packed {
    logic loadActive;
    logic loadInactive;
    logic countDown;
    logic expActive;
    logic expInactive;
  } cadStrobe_t;
endpackage

// File: rtl/tone_cadence_dp.sv
module tone_cadence_dp
  import tone_cadence_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [CNT_W-1:0]    activeLen,
  input  logic [CNT_W-1:0]    inactiveLen,
  input  logic [SAMPLE_W-1:0] oscSample,
  input  cadStrobe_t          strobe,
  input  logic [NUM_EXP-1:0]  statusClr,
  output logic                countIsOne,
  output logic                zeroCross,
  output logic [NUM_EXP-1:0]  status
);
  localparam int SIGN_BIT = SAMPLE_W - 1;
  localparam logic [CNT_W-1:0] ONE_TICK = CNT_W'(1);

  logic [CNT_W-1:0]    count;
  logic [CNT_W-1:0]    activeLoad;
  logic [CNT_W-1:0]    inactiveLoad;
  logic [SAMPLE_W-1:0] prevSample;
  logic [NUM_EXP-1:0]  expVec;

  // zero length behaves as one tick (R4)
  assign activeLoad   = (activeLen == '0) ? ONE_TICK : activeLen;
  assign inactiveLoad = (inactiveLen == '0) ? ONE_TICK : inactiveLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.loadActive) begin
      count <= activeLoad;
    end else if (strobe.loadInactive) begin
      count <= inactiveLoad;
    end else if (strobe.countDown) begin
      count <= count - ONE_TICK;
    end
  end

  assign countIsOne = (count == ONE_TICK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSample <= '0;
    end else if (tick) begin
      prevSample <= oscSample;
    end
  end

  // sign change against the last tick's sample, or an exact zero (R7)
  assign zeroCross = tick &&
    ((oscSample == '0) || (oscSample[SIGN_BIT] != prevSample[SIGN_BIT]));

  assign expVec[EXP_ACTIVE]   = strobe.expActive;
  assign expVec[EXP_INACTIVE] = strobe.expInactive;

  generate
    for (genvar i = 0; i < NUM_EXP; i++) begin : g_status
      always_ff @(posedge clk) begin
        if (!rstN) begin
          status[i] <= 1'b0;
        end else begin
          status[i] <= expVec[i] | (status[i] & ~statusClr[i]);
        end
      end

      assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
        (status[i] && !statusClr[i]) |=> status[i]);

      assert_expiry_beats_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
        expVec[i] |=> status[i]);
    end
  endgenerate

  assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadActive || strobe.loadInactive) |=> (count != '0));
endmodule

// File: rtl/tone_cadence_ctl.sv
module tone_cadence_ctl
  import tone_cadence_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       oscEnable,
  input  logic       syncStart,
  input  logic       activeTimerEn,
  input  logic       inactiveTimerEn,
  input  logic       zeroCrossEn,
  input  logic       countIsOne,
  input  logic       zeroCross,
  output cadStrobe_t strobe,
  output logic       toneOn
);
  cadState_t state;
  cadState_t stateNext;

  always_comb begin
    stateNext = state;
    strobe = '0;
    if (!oscEnable) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!syncStart || tick) begin
            strobe.loadActive = 1'b1;
            stateNext = ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (activeTimerEn && tick) begin
            if (countIsOne) begin
              strobe.expActive = 1'b1;
              if (zeroCrossEn) begin
                stateNext = ST_DRAIN;
              end else if (inactiveTimerEn) begin
                strobe.loadInactive = 1'b1;
                stateNext = ST_INACTIVE;
              end else begin
                stateNext = ST_DONE;
              end
            end else begin
              strobe.countDown = 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (zeroCross) begin
            if (inactiveTimerEn) begin
              strobe.loadInactive = 1'b1;
              stateNext = ST_INACTIVE;
            end else begin
              stateNext = ST_DONE;
            end
          end
        end
        ST_INACTIVE: begin
          if (tick) begin
            if (countIsOne) begin
              strobe.expInactive = 1'b1;
              strobe.loadActive = 1'b1;
              stateNext = ST_ACTIVE;
            end else begin
              strobe.countDown = 1'b1;
            end
          end
        end
        ST_DONE: stateNext = ST_DONE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign toneOn = (state == ST_ACTIVE) || (state == ST_DRAIN);

  assert_disable_stops_R11: assert property (@(posedge clk) disable iff (!rstN)
    !oscEnable |=> !toneOn);

  assert_hold_untimed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !activeTimerEn && oscEnable) |=> toneOn);

  assert_wait_crossing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN && !zeroCross && oscEnable) |=> toneOn);

  assert_done_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |-> !toneOn);
endmodule

// File: rtl/tone_cadence_timer.sv
module tone_cadence_timer
  import tone_cadence_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                oscEnable,
  input  logic                syncStart,
  input  logic                activeTimerEn,
  input  logic                inactiveTimerEn,
  input  logic                zeroCrossEn,
  input  logic [CNT_W-1:0]    activeLen,
  input  logic [CNT_W-1:0]    inactiveLen,
  input  logic [SAMPLE_W-1:0] oscSample,
  input  logic [1:0]          intEnable,
  input  logic [1:0]          statusClr,
  output logic                toneOn,
  output logic [1:0]          status,
  output logic                irq
);
  cadStrobe_t strobe;
  logic       countIsOne;
  logic       zeroCross;

  tone_cadence_ctl u_ctl (
    .clk             (clk),
    .rstN            (rstN),
    .tick            (tick),
    .oscEnable       (oscEnable),
    .syncStart       (syncStart),
    .activeTimerEn   (activeTimerEn),
    .inactiveTimerEn (inactiveTimerEn),
    .zeroCrossEn     (zeroCrossEn),
    .countIsOne      (countIsOne),
    .zeroCross       (zeroCross),
    .strobe          (strobe),
    .toneOn          (toneOn)
  );

  tone_cadence_dp #(.CNT_W(CNT_W), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .activeLen   (activeLen),
    .inactiveLen (inactiveLen),
    .oscSample   (oscSample),
    .strobe      (strobe),
    .statusClr   (statusClr),
    .countIsOne  (countIsOne),
    .zeroCross   (zeroCross),
    .status      (status)
  );

  assign irq = |(status & intEnable);

  assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (status != 2'b00));
endmodule

// File: tb/sim_tone_cadence_timer.sv
module sim_tone_cadence_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        oscEnable = 1'b0;
  logic        syncStart = 1'b0;
  logic        activeTimerEn = 1'b0;
  logic        inactiveTimerEn = 1'b0;
  logic        zeroCrossEn = 1'b0;
  logic [15:0] activeLen = '0;
  logic [15:0] inactiveLen = '0;
  logic [15:0] oscSample = '0;
  logic [1:0]  intEnable = '0;
  logic [1:0]  statusClr = '0;
  logic        toneOn;
  logic [1:0]  status;
  logic        irq;

  int total = 0;
  int bad = 0;

  localparam int M_IDLE = 0, M_ACT = 1, M_DRAIN = 2, M_INACT = 3, M_DONE = 4;
  int          mS = M_IDLE;
  int          mCnt = 0;
  logic [15:0] mPrev = '0;
  logic [1:0]  mStat = '0;
  logic [1:0]  mExp = '0;
  logic [1:0]  mClrSeen = '0;

  always #5 clk = ~clk;

  tone_cadence_timer u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .oscEnable(oscEnable),
    .syncStart(syncStart), .activeTimerEn(activeTimerEn),
    .inactiveTimerEn(inactiveTimerEn), .zeroCrossEn(zeroCrossEn),
    .activeLen(activeLen), .inactiveLen(inactiveLen), .oscSample(oscSample),
    .intEnable(intEnable), .statusClr(statusClr), .toneOn(toneOn),
    .status(status), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int len1(logic [15:0] v);
    return (v == 16'd0) ? 1 : int'(v);
  endfunction

  task automatic modelStep();
    logic zc;
    mExp = '0;
    mClrSeen = statusClr;
    if (!rstN) begin
      mS = M_IDLE; mCnt = 0; mPrev = '0; mStat = '0;
      return;
    end
    zc = tick && ((oscSample == 16'd0) || (oscSample[15] != mPrev[15]));
    if (!oscEnable) begin
      mS = M_IDLE;
    end else begin
      case (mS)
        M_IDLE: if (!syncStart || tick) begin mS = M_ACT; mCnt = len1(activeLen); end
        M_ACT: if (activeTimerEn && tick) begin
          if (mCnt == 1) begin
            mExp[0] = 1'b1;
            if (zeroCrossEn) mS = M_DRAIN;
            else if (inactiveTimerEn) begin mS = M_INACT; mCnt = len1(inactiveLen); end
            else mS = M_DONE;
          end else mCnt--;
        end
        M_DRAIN: if (zc) begin
          if (inactiveTimerEn) begin mS = M_INACT; mCnt = len1(inactiveLen); end
          else mS = M_DONE;
        end
        M_INACT: if (tick) begin
          if (mCnt == 1) begin mExp[1] = 1'b1; mS = M_ACT; mCnt = len1(activeLen); end
          else mCnt--;
        end
        default: ;
      endcase
    end
    if (tick) mPrev = oscSample;
    mStat = mExp | (mStat & ~statusClr);
  endtask

  task automatic compareAll();
    if (!rstN) return;
    chk("R3", "toneOn", 32'(toneOn), 32'((mS == M_ACT) || (mS == M_DRAIN)));
    chk("R8", "status", 32'(status), 32'(mStat));
    chk("R10", "irq", 32'(irq), 32'(|(mStat & intEnable)));
    for (int i = 0; i < 2; i++)
      if (mExp[i] && mClrSeen[i]) chk("R9", "status bit on clear collision", 32'(status[i]), 32'd1);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    cyc(); cyc();
    rstN = 1'b1;
    cyc();
    chk("R1", "toneOn after reset", 32'(toneOn), 32'd0);
    chk("R1", "status after reset", 32'(status), 32'd0);
    chk("R1", "irq after reset", 32'(irq), 32'd0);

    // R2 immediate start
    activeTimerEn = 1; inactiveTimerEn = 1; activeLen = 5; inactiveLen = 5;
    oscEnable = 1; syncStart = 0; tick = 0;
    cyc();
    chk("R2", "immediate start", 32'(toneOn), 32'd1);
    // R11 stop
    oscEnable = 0;
    cyc();
    chk("R11", "stop on disable", 32'(toneOn), 32'd0);
    // R2 synchronised start
    syncStart = 1; oscEnable = 1;
    cyc(); cyc();
    chk("R2", "sync waits for tick", 32'(toneOn), 32'd0);
    tick = 1;
    cyc();
    chk("R2", "sync start on tick", 32'(toneOn), 32'd1);
    tick = 0; oscEnable = 0;
    cyc();

    // R4 zero lengths: one tick each
    activeLen = 0; inactiveLen = 0; syncStart = 0; oscEnable = 1;
    cyc();
    chk("R4", "on after start", 32'(toneOn), 32'd1);
    tick = 1;
    cyc(); chk("R4", "off after one tick", 32'(toneOn), 32'd0);
    cyc(); chk("R4", "on after one tick", 32'(toneOn), 32'd1);
    cyc(); chk("R4", "off again", 32'(toneOn), 32'd0);
    chk("R8", "both expiries latched", 32'(status), 32'd3);
    // R9 clear collides with inactive expiry
    statusClr = 2'b11;
    cyc();
    chk("R9", "expiry wins over clear", 32'(status), 32'd2);
    tick = 0; statusClr = 2'b00;
    oscEnable = 0;
    cyc();
    chk("R11", "status kept on disable", 32'(status), 32'd2);
    // R10 masking
    intEnable = 2'b01; #1;
    chk("R10", "masked irq", 32'(irq), 32'd0);
    intEnable = 2'b10; #1;
    chk("R10", "unmasked irq", 32'(irq), 32'd1);
    cyc();
    chk("R10", "mask leaves status", 32'(status), 32'd2);

    // R5 active timer disabled
    activeTimerEn = 0; activeLen = 1; oscEnable = 1;
    cyc();
    tick = 1;
    repeat (6) cyc();
    chk("R5", "tone held on", 32'(toneOn), 32'd1);
    tick = 0; oscEnable = 0;
    cyc();

    // R6 single burst
    activeTimerEn = 1; inactiveTimerEn = 0; activeLen = 2; oscEnable = 1;
    cyc();
    tick = 1;
    cyc(); chk("R3", "on during burst", 32'(toneOn), 32'd1);
    cyc(); chk("R6", "off after burst", 32'(toneOn), 32'd0);
    repeat (4) cyc();
    chk("R6", "stays off", 32'(toneOn), 32'd0);
    tick = 0; oscEnable = 0;
    cyc();

    // R7 zero-cross wait
    zeroCrossEn = 1; inactiveTimerEn = 1; activeLen = 1; inactiveLen = 3;
    oscSample = 16'd5; oscEnable = 1;
    cyc();
    tick = 1;
    cyc(); chk("R7", "held past expiry", 32'(toneOn), 32'd1);
    oscSample = 16'd7;
    cyc(); chk("R7", "no crossing", 32'(toneOn), 32'd1);
    oscSample = 16'd0;
    cyc(); chk("R7", "exact zero ends tone", 32'(toneOn), 32'd0);
    oscSample = 16'hFFF0;
    cyc(); cyc(); cyc();
    chk("R7", "back on after inactive", 32'(toneOn), 32'd1);
    cyc(); chk("R7", "held, same sign", 32'(toneOn), 32'd1);
    oscSample = 16'd3;
    cyc(); chk("R7", "sign change ends tone", 32'(toneOn), 32'd0);
    tick = 0; oscEnable = 0; zeroCrossEn = 0;
    cyc();

    // random segments checked against the model every cycle
    for (int seg = 0; seg < 40; seg++) begin
      int div;
      div = 1 + int'($urandom_range(3));
      activeLen = 16'($urandom_range(6));
      inactiveLen = 16'($urandom_range(6));
      activeTimerEn = ($urandom_range(7) != 0);
      inactiveTimerEn = ($urandom_range(5) != 0);
      zeroCrossEn = $urandom_range(1);
      syncStart = $urandom_range(1);
      intEnable = 2'($urandom_range(3));
      oscEnable = 1;
      for (int c = 0; c < 100; c++) begin
        tick = ((c % div) == 0);
        oscSample = 16'($signed(int'($urandom_range(6)) - 3));
        statusClr[0] = ($urandom_range(15) == 0);
        statusClr[1] = ($urandom_range(15) == 0);
        if ($urandom_range(149) == 0) oscEnable = ~oscEnable;
        cyc();
      end
      statusClr = 0; oscEnable = 0; tick = 0;
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule